// File: doc/BRIEF.md
# Parallel Camera Frame Capture Controller

This block sits behind an 8-bit parallel camera port. Pixel bytes arrive with a horizontal and a vertical sync line, and the whole block runs in the pixel clock domain. The block works out which bytes belong to a captured frame, packs them four at a time into 32-bit words, and offers each word on a valid/ready output. That output stands in for a DMA request.

Static configuration inputs choose the following:

- the blanking level of each sync line
- the clock edge that samples the port
- JPEG mode, where the horizontal sync acts as a plain byte enable
- an optional crop window
- single-frame (snapshot) or continuous capture
- the capture enable

Capture starts only at a frame boundary and ends only at one. The `captureOn` output shows the effective enable state. It stays high through a frame that is still being captured after the enable input drops. It falls on its own after the single frame in snapshot mode.

Top module: `cam_capture`

## Requirements
- R1: After reset, `outValid`, `captureOn` and `overrun` are low.
- R2: A sync line whose sampled level equals its polarity setting marks blanking: on `camVsync` that is between frames, on `camHsync` it is no valid byte. The opposite level marks the active frame or byte, for either polarity value.
- R3: With `cfgRiseEdge`=1 the port is sampled on the rising clock edge. With 0 it is sampled on the falling edge. The port value present at the other edge has no effect on the captured words.
- R4: Raising `cfgCapture` raises `captureOn` within two cycles. No byte is taken until the next rising transition into an active frame, so a frame already in progress is skipped entirely. `captureOn` never rises while `cfgCapture` is low.
- R5: Taken bytes are packed little-endian: the first byte of a word goes to `outData[7:0]` and the fourth to `outData[31:24]`. A word is offered once its fourth byte is taken, and words leave in byte order.
- R6: In continuous mode (`cfgSnapshot`=0) every frame is captured while `cfgCapture` is high. If `cfgCapture` drops during a captured frame, that frame still completes in full. `captureOn` then falls after the frame end and the next frame is not captured.
- R7: In snapshot mode exactly one frame is captured. `captureOn` falls after that frame even though `cfgCapture` stays high. A new capture needs `cfgCapture` to go low and then high again.
- R8: With `cfgCrop`=1 and JPEG off, a byte is kept only if its column and its line both fall inside the window. The column is the byte's 0-based index within its active line; it must lie in [`cropX`, `cropX`+`cropW`). The line is the 0-based index of its active line within the frame; it must lie in [`cropY`, `cropY`+`cropH`).
- R9: A crop window larger than the picture captures the whole picture.
- R10: In JPEG mode the crop setting is ignored. At frame end a partial word is flushed with its unused upper bytes zero. Outside JPEG mode a partial word left at frame end is discarded.
- R11: A word offered with `outReady` low is held stable until accepted. If another word completes while one is still pending and not accepted in that cycle, the new word is dropped and `overrun` is set. `overrun` stays set until the start of the next captured frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| camData | input | 8 | Camera pixel byte |
| camHsync | input | 1 | Horizontal sync, or byte enable in JPEG mode |
| camVsync | input | 1 | Vertical sync |
| cfgHsPol | input | 1 | Blanking level of `camHsync` |
| cfgVsPol | input | 1 | Blanking level of `camVsync` |
| cfgRiseEdge | input | 1 | 1: sample on the rising edge, 0: on the falling edge |
| cfgJpeg | input | 1 | JPEG byte-stream mode |
| cfgCrop | input | 1 | Crop window enable |
| cfgSnapshot | input | 1 | 1: single frame, 0: continuous |
| cfgCapture | input | 1 | Capture enable request |
| cropX | input | 12 | Window first column, in bytes |
| cropY | input | 12 | Window first line |
| cropW | input | 12 | Window width, in bytes |
| cropH | input | 12 | Window height, in lines |
| outReady | input | 1 | Consumer accepts the offered word |
| outValid | output | 1 | A packed word is offered |
| outData | output | 32 | Packed word, first byte in bits 7:0 |
| captureOn | output | 1 | Effective capture enable |
| overrun | output | 1 | A completed word was dropped |

## Verification
Two things can happen in the same cycle: a new word completes in the packer, and the pending output word is accepted by the consumer. Correct behaviour is to load the new word with no drop. The bench provokes this by raising `outReady` on only one cycle in four while bytes stream in every cycle. Some acceptance cycles then line up with word completion. The result is judged by the scoreboard receiving every expected word in order with `overrun` still low. A separate frame, captured with `outReady` held low, shows the other outcome: the words that complete behind the held word are dropped and the flag is set.

// File: rtl/cam_capture_pkg.sv
package cam_capture_pkg;

  // Strobes passed from the control to the datapath, one cycle each.
  typedef struct packed {
    logic take;     // accept the sampled byte into the packer
    logic flush;    // frame end, JPEG: emit partial word zero padded
    logic drop;     // frame end, uncompressed: discard partial word
    logic restart;  // start of a captured frame: clear packer and overrun
  } capStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_HOLD  = 2'd3
  } capState_t;

endpackage

// File: rtl/cam_capture_sampler.sv
module cam_capture_sampler #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgRiseEdge,
  input  logic [PIX_W-1:0] pinData,
  input  logic             pinHsync,
  input  logic             pinVsync,
  output logic [PIX_W-1:0] smpData,
  output logic             smpHsync,
  output logic             smpVsync
);
  localparam int BUS_W = PIX_W + 2;

  logic [BUS_W-1:0] riseQ;
  logic [BUS_W-1:0] fallQ;
  logic [BUS_W-1:0] fallRetimed;

  // Rising-edge capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) riseQ <= '0;
    else       riseQ <= {pinVsync, pinHsync, pinData};
  end

  // Falling-edge capture, brought back onto the rising edge so both paths
  // present their sample in the same cycle.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallQ <= '0;
    else       fallQ <= {pinVsync, pinHsync, pinData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fallRetimed <= '0;
    else       fallRetimed <= fallQ;
  end

  assign {smpVsync, smpHsync, smpData} = cfgRiseEdge ? riseQ : fallRetimed;

endmodule

// File: rtl/cam_capture_ctrl.sv
module cam_capture_ctrl
  import cam_capture_pkg::*;
#(
  parameter int COL_W = 12,
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             smpHsync,
  input  logic             smpVsync,
  input  logic             cfgHsPol,
  input  logic             cfgVsPol,
  input  logic             cfgJpeg,
  input  logic             cfgCrop,
  input  logic             cfgSnapshot,
  input  logic             cfgCapture,
  input  logic [COL_W-1:0] cropX,
  input  logic [ROW_W-1:0] cropY,
  input  logic [COL_W-1:0] cropW,
  input  logic [ROW_W-1:0] cropH,
  output capStrobe_t       strobe,
  output logic             captureOn
);
  capState_t  state, stateNext;
  logic       frameAct, lineAct;
  logic       prevFrame, prevLine;
  logic       sof, eof;
  logic [COL_W-1:0] colCnt;
  logic [ROW_W-1:0] rowCnt;
  logic [COL_W:0]   colEnd;
  logic [ROW_W:0]   rowEnd;
  logic       inWindow, keepByte;

  // Level equal to polarity setting means blanking.
  assign frameAct = (smpVsync != cfgVsPol);
  assign lineAct  = (smpHsync != cfgHsPol);
  assign sof      = frameAct && !prevFrame;
  assign eof      = !frameAct && prevFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFrame <= 1'b1;  // a genuine rising transition is needed first
      prevLine  <= 1'b0;
    end else begin
      prevFrame <= frameAct;
      prevLine  <= lineAct;
    end
  end

  // Byte position inside the line and line position inside the frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else begin
      if (!lineAct || !frameAct)  colCnt <= '0;
      else if (colCnt != '1)      colCnt <= colCnt + 1'b1;

      if (!frameAct)                                    rowCnt <= '0;
      else if (prevLine && !lineAct && rowCnt != '1)    rowCnt <= rowCnt + 1'b1;
    end
  end

  assign colEnd   = {1'b0, cropX} + {1'b0, cropW};
  assign rowEnd   = {1'b0, cropY} + {1'b0, cropH};
  assign inWindow = (colCnt >= cropX) && ({1'b0, colCnt} < colEnd) &&
                    (rowCnt >= cropY) && ({1'b0, rowCnt} < rowEnd);
  assign keepByte = cfgJpeg || !cfgCrop || inWindow;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (cfgCapture) stateNext = ST_ARMED;
      ST_ARMED: begin
        if (!cfgCapture) stateNext = ST_IDLE;
        else if (sof)    stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (eof) begin
          if (cfgSnapshot)      stateNext = ST_HOLD;
          else if (!cfgCapture) stateNext = ST_IDLE;
          else                  stateNext = ST_ARMED;
        end
      end
      ST_HOLD:  if (!cfgCapture) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.take    = (state == ST_RUN) && frameAct && lineAct && keepByte;
    strobe.flush   = (state == ST_RUN) && eof && cfgJpeg;
    strobe.drop    = (state == ST_RUN) && eof && !cfgJpeg;
    strobe.restart = (state == ST_ARMED) && sof && cfgCapture;
  end

  assign captureOn = (state == ST_ARMED) || (state == ST_RUN);

endmodule

// File: rtl/cam_capture_datapath.sv
module cam_capture_datapath
  import cam_capture_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int WORD_PIX  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  capStrobe_t                strobe,
  input  logic [PIX_W-1:0]          smpData,
  input  logic                      outReady,
  output logic                      outValid,
  output logic [PIX_W*WORD_PIX-1:0] outData,
  output logic                      overrun
);
  localparam int WORD_W = PIX_W * WORD_PIX;
  localparam int IDX_W  = (WORD_PIX > 1) ? $clog2(WORD_PIX) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_PIX - 1);

  logic [IDX_W-1:0]  byteIdx;
  logic [WORD_W-1:0] packReg;
  logic [WORD_W-1:0] packWithByte;
  logic [WORD_W-1:0] wordNew;
  logic              wordDone;
  logic              drain;

  // Lane insert: each lane either keeps its content or takes the new byte.
  generate
    for (genvar lane = 0; lane < WORD_PIX; lane++) begin : g_lane
      assign packWithByte[lane*PIX_W +: PIX_W] =
        (byteIdx == IDX_W'(lane)) ? smpData : packReg[lane*PIX_W +: PIX_W];
    end
  endgenerate

  always_comb begin
    wordDone = 1'b0;
    wordNew  = packWithByte;
    if (strobe.take && byteIdx == LAST_IDX) begin
      wordDone = 1'b1;
    end else if (strobe.flush && byteIdx != '0) begin
      wordDone = 1'b1;
      wordNew  = packReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
      packReg <= '0;
    end else if (strobe.restart || strobe.flush || strobe.drop || wordDone) begin
      byteIdx <= '0;
      packReg <= '0;
    end else if (strobe.take) begin
      byteIdx <= byteIdx + 1'b1;
      packReg <= packWithByte;
    end
  end

  assign drain = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      overrun  <= 1'b0;
    end else begin
      if (wordDone && (!outValid || drain)) begin
        outValid <= 1'b1;
        outData  <= wordNew;
      end else if (drain) begin
        outValid <= 1'b0;
      end

      if (strobe.restart)                     overrun <= 1'b0;
      else if (wordDone && outValid && !drain) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/cam_capture.sv
module cam_capture
  import cam_capture_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int WORD_PIX = 4,
  parameter int COL_W    = 12,
  parameter int ROW_W    = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [PIX_W-1:0]          camData,
  input  logic                      camHsync,
  input  logic                      camVsync,
  input  logic                      cfgHsPol,
  input  logic                      cfgVsPol,
  input  logic                      cfgRiseEdge,
  input  logic                      cfgJpeg,
  input  logic                      cfgCrop,
  input  logic                      cfgSnapshot,
  input  logic                      cfgCapture,
  input  logic [COL_W-1:0]          cropX,
  input  logic [ROW_W-1:0]          cropY,
  input  logic [COL_W-1:0]          cropW,
  input  logic [ROW_W-1:0]          cropH,
  input  logic                      outReady,
  output logic                      outValid,
  output logic [PIX_W*WORD_PIX-1:0] outData,
  output logic                      captureOn,
  output logic                      overrun
);
  logic [PIX_W-1:0] smpData;
  logic             smpHsync, smpVsync;
  capStrobe_t       strobe;

  cam_capture_sampler #(.PIX_W(PIX_W)) u_sampler (
    .clk(clk), .rstN(rstN), .cfgRiseEdge(cfgRiseEdge),
    .pinData(camData), .pinHsync(camHsync), .pinVsync(camVsync),
    .smpData(smpData), .smpHsync(smpHsync), .smpVsync(smpVsync)
  );

  cam_capture_ctrl #(.COL_W(COL_W), .ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .smpHsync(smpHsync), .smpVsync(smpVsync),
    .cfgHsPol(cfgHsPol), .cfgVsPol(cfgVsPol), .cfgJpeg(cfgJpeg),
    .cfgCrop(cfgCrop), .cfgSnapshot(cfgSnapshot), .cfgCapture(cfgCapture),
    .cropX(cropX), .cropY(cropY), .cropW(cropW), .cropH(cropH),
    .strobe(strobe), .captureOn(captureOn)
  );

  cam_capture_datapath #(.PIX_W(PIX_W), .WORD_PIX(WORD_PIX)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .smpData(smpData),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .overrun(overrun)
  );

endmodule

// File: rtl/cam_capture_checker.sv
module cam_capture_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input logic              overrun,
  input logic              captureOn,
  input logic              cfgCapture
);
  // R11: an unaccepted word stays offered and unchanged
  a_r11_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  // R11: overrun only appears when a word was stuck in the previous cycle
  a_r11_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(outValid && !outReady));

  // R4: with capture off and nothing pending, no word appears
  a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !captureOn && !outValid |=> !outValid);

  // R4: capture never turns itself on without the enable
  a_r4_no_self_start: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCapture && !captureOn |=> !captureOn);

endmodule

bind cam_capture cam_capture_checker #(.WORD_W(PIX_W*WORD_PIX)) u_checker (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .outData(outData), .overrun(overrun), .captureOn(captureOn),
  .cfgCapture(cfgCapture)
);

// File: tb/test_cam_capture.sv
`timescale 1ns/1ps
module test_cam_capture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  camData = '0;
  logic        camHsync = 1'b0, camVsync = 1'b0;
  logic        cfgHsPol = 1'b0, cfgVsPol = 1'b0, cfgRiseEdge = 1'b1;
  logic        cfgJpeg = 1'b0, cfgCrop = 1'b0, cfgSnapshot = 1'b0, cfgCapture = 1'b0;
  logic [11:0] cropX = '0, cropY = '0, cropW = '0, cropH = '0;
  logic        outReady = 1'b1;
  logic        outValid, captureOn, overrun;
  logic [31:0] outData;

  int checks = 0, errors = 0;
  int readyMode = 0;   // 0 always ready, 1 never, 2 one cycle in four
  int garbMode = 0;    // 0 none, 1 junk in second half, 2 junk in first half
  int rdyCnt = 0;
  logic [31:0] sb[$];

  always #4 clk = ~clk;  // 125 MHz

  cam_capture i_cam_capture (
    .clk(clk), .rstN(rstN), .camData(camData), .camHsync(camHsync),
    .camVsync(camVsync), .cfgHsPol(cfgHsPol), .cfgVsPol(cfgVsPol),
    .cfgRiseEdge(cfgRiseEdge), .cfgJpeg(cfgJpeg), .cfgCrop(cfgCrop),
    .cfgSnapshot(cfgSnapshot), .cfgCapture(cfgCapture), .cropX(cropX),
    .cropY(cropY), .cropW(cropW), .cropH(cropH), .outReady(outReady),
    .outValid(outValid), .outData(outData), .captureOn(captureOn),
    .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    rdyCnt++;
    outReady = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? 1'b0 : (rdyCnt % 4 == 0);
  end

  // Monitor: compare every accepted word against the scoreboard.
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (sb.size() == 0) begin
        check(1'b0, "R5", "unexpected word", outData, 0);
      end else begin
        logic [31:0] exp;
        exp = sb.pop_front();
        check(outData === exp, "R5", "word data", outData, exp);
      end
    end
  end

  task automatic drv(input logic [7:0] d, input logic h, input logic v);
    @(posedge clk);
    #1;
    camHsync = h;
    camVsync = v;
    camData  = (garbMode == 2) ? ~d : d;
    if (garbMode != 0) begin
      #4;
      camData = (garbMode == 1) ? ~d : d;
    end
  endtask

  function automatic logic [7:0] pix(int seed, int l, int c);
    return 8'((seed * 37 + l * 11 + c * 3 + 5) & 255);
  endfunction

  function automatic bit keep(int l, int c);
    if (cfgJpeg || !cfgCrop) return 1'b1;
    return (c >= int'(cropX)) && (c < int'(cropX) + int'(cropW)) &&
           (l >= int'(cropY)) && (l < int'(cropY) + int'(cropH));
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drv(8'h00, cfgHsPol, cfgVsPol);
  endtask

  // act: 0 none, 1 raise enable, 2 drop enable (after line actLine)
  task automatic sendFrame(input int nL, input int nB, input int seed, input bit expCap,
                           input int actLine, input int act, input int maxWords,
                           input bit endCheck, input string tag);
    logic [7:0] kept[$];
    int n, nw;
    if (expCap)
      for (int l = 0; l < nL; l++)
        for (int c = 0; c < nB; c++)
          if (keep(l, c)) kept.push_back(pix(seed, l, c));
    n = kept.size();
    nw = n / 4;
    if (cfgJpeg && (n % 4) != 0) nw++;
    if (maxWords >= 0 && nw > maxWords) nw = maxWords;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] word;
      word = '0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < n) word[b*8 +: 8] = kept[w * 4 + b];
      sb.push_back(word);
    end
    idle(4);
    for (int i = 0; i < 2; i++) drv(8'h00, cfgHsPol, ~cfgVsPol);
    for (int l = 0; l < nL; l++) begin
      for (int c = 0; c < nB; c++) drv(pix(seed, l, c), ~cfgHsPol, ~cfgVsPol);
      for (int i = 0; i < 2; i++) drv(8'h00, cfgHsPol, ~cfgVsPol);
      if (l == actLine && act == 1) cfgCapture = 1'b1;
      if (l == actLine && act == 2) cfgCapture = 1'b0;
    end
    idle(14);
    if (endCheck) check(sb.size() == 0, tag, "words missing", sb.size(), 0);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    settle();
    check(outValid == 0 && captureOn == 0 && overrun == 0, "R1", "reset outputs",
          {outValid, captureOn, overrun}, 0);

    // R4: enable in mid-frame, that frame skipped
    sendFrame(3, 8, 1, 1'b0, 0, 1, -1, 1'b1, "R4");
    check(captureOn == 1, "R4", "captureOn after enable", captureOn, 1);
    // R6: continuous, consecutive frames
    sendFrame(3, 8, 2, 1'b1, -1, 0, -1, 1'b1, "R6");
    sendFrame(2, 12, 3, 1'b1, -1, 0, -1, 1'b1, "R6");
    // R6: drop enable mid-frame, frame completes
    sendFrame(4, 8, 4, 1'b1, 1, 2, -1, 1'b1, "R6");
    check(captureOn == 0, "R6", "captureOn after frame end", captureOn, 0);
    sendFrame(2, 8, 5, 1'b0, -1, 0, -1, 1'b1, "R6");

    // R7: snapshot
    cfgSnapshot = 1'b1;
    cfgCapture = 1'b1;
    sendFrame(2, 8, 6, 1'b1, -1, 0, -1, 1'b1, "R7");
    check(captureOn == 0, "R7", "snapshot self clear", captureOn, 0);
    sendFrame(2, 8, 7, 1'b0, -1, 0, -1, 1'b1, "R7");
    cfgCapture = 1'b0;
    idle(3);
    cfgCapture = 1'b1;
    idle(3);
    settle();
    check(captureOn == 1, "R7", "re-armed", captureOn, 1);
    sendFrame(1, 12, 8, 1'b1, -1, 0, -1, 1'b1, "R7");
    cfgCapture = 1'b0;
    cfgSnapshot = 1'b0;
    idle(3);

    // R8: crop window
    cfgCapture = 1'b1;
    cfgCrop = 1'b1; cropX = 12'd2; cropY = 12'd1; cropW = 12'd8; cropH = 12'd2;
    sendFrame(4, 12, 9, 1'b1, -1, 0, -1, 1'b1, "R8");
    // R9: oversize window
    cropX = 12'd0; cropY = 12'd0; cropW = 12'd100; cropH = 12'd100;
    sendFrame(3, 8, 10, 1'b1, -1, 0, -1, 1'b1, "R9");
    // R10: uncompressed partial word discarded (6 bytes kept)
    cropX = 12'd1; cropY = 12'd0; cropW = 12'd6; cropH = 12'd1;
    sendFrame(2, 8, 11, 1'b1, -1, 0, -1, 1'b1, "R10");
    // R10: JPEG ignores crop, flushes partial word
    cfgJpeg = 1'b1;
    sendFrame(2, 7, 12, 1'b1, -1, 0, -1, 1'b1, "R10");
    cfgJpeg = 1'b0;
    cfgCrop = 1'b0;

    // R2: inverted polarities (changed while capture is off)
    cfgCapture = 1'b0;
    idle(4);
    cfgHsPol = 1'b1; cfgVsPol = 1'b1;
    idle(4);
    cfgCapture = 1'b1;
    sendFrame(3, 8, 13, 1'b1, -1, 0, -1, 1'b1, "R2");
    cfgCapture = 1'b0;
    idle(4);
    cfgHsPol = 1'b0; cfgVsPol = 1'b0;

    // R3: falling edge with junk in the second half
    cfgRiseEdge = 1'b0;
    garbMode = 1;
    idle(4);
    cfgCapture = 1'b1;
    sendFrame(2, 8, 14, 1'b1, -1, 0, -1, 1'b1, "R3");
    cfgCapture = 1'b0;
    idle(4);
    // R3: rising edge with junk in the first half
    cfgRiseEdge = 1'b1;
    garbMode = 2;
    idle(4);
    cfgCapture = 1'b1;
    sendFrame(2, 8, 15, 1'b1, -1, 0, -1, 1'b1, "R3");
    garbMode = 0;

    // R11: sparse ready, acceptance coincides with completion
    readyMode = 2;
    sendFrame(3, 16, 16, 1'b1, -1, 0, -1, 1'b1, "R11");
    check(overrun == 0, "R11", "no overrun with sparse ready", overrun, 0);
    // R11: ready held low, later words dropped
    readyMode = 1;
    sendFrame(1, 12, 17, 1'b1, -1, 0, 1, 1'b0, "R11");
    settle();
    check(overrun == 1, "R11", "overrun set", overrun, 1);
    check(outValid == 1, "R11", "first word held", outValid, 1);
    readyMode = 0;
    idle(4);
    check(sb.size() == 0, "R11", "held word delivered", sb.size(), 0);
    check(overrun == 1, "R11", "overrun sticky", overrun, 1);
    sendFrame(1, 8, 18, 1'b1, -1, 0, -1, 1'b1, "R11");
    check(overrun == 0, "R11", "overrun cleared at next frame", overrun, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule